// File: doc/BRIEF.md
# Packed Pixel Format Expander

The expander turns one packed source pixel into a 32-bit colour value with 8 bits each for alpha, red, green and blue. A plane control word steers the conversion. Its low five bits pick the packed layout, one flag reverses the byte order of the stored pixel, another moves the alpha (or pad) field from the most-significant end of the pixel to the least-significant end, and a third picks either the full 0..255 alpha range or a half range that tops out at 128.

The source pixel arrives right-aligned in a 32-bit word and occupies 2, 3 or 4 bytes depending on the layout. Conversion takes one register stage behind a valid/ready handshake, so a display pipeline can stream one pixel per cycle through it. Layout codes that the block does not know produce an all-zero result with an unsupported flag raised for that pixel.

Top module: `pix_expand`

## Requirements
- R1: The layout code is in_ctl[4:0]. Code 0: R[15:11] G[10:5] B[4:0]. Codes 1 and 2: R[23:16] G[15:8] B[7:0], and code 2 has a pad byte at [31:24]. Code 4: A[23:16] R[15:11] G[10:5] B[4:0]. Code 5: A[31:24] R[23:16] G[15:8] B[7:0]. Code 6: A[15] R[14:10] G[9:5] B[4:0]. Code 7: A[15:12] R[11:8] G[7:4] B[3:0]. Codes 0, 6 and 7 use 2 bytes, codes 1 and 4 use 3 bytes, and codes 2 and 5 use 4 bytes.
- R2: A field narrower than 8 bits is widened by repeating its bits from the top down: a 5-bit value v gives {v, v[4:2]}, a 6-bit value gives {v, v[5:4]}, and a 4-bit value gives {v, v}.
- R3: When in_ctl[23] is 1, the pixel's bytes (2, 3 or 4 of them, per R1) are taken in reversed order before the fields are extracted.
- R4: When in_ctl[6] is 1, the alpha or pad field (8 bits for codes 2, 4 and 5, 1 bit for code 6, 4 bits for code 7) sits at the least-significant end of the pixel, with the colour fields above it in the same order. This swap is applied after any byte reversal. For codes 0 and 1 the flag has no effect.
- R5: When in_ctl[5] is 1, the alpha range is 0..255 and an 8-bit alpha passes through unchanged. When it is 0, the maximum is 128 and an 8-bit alpha a becomes (a+1)>>1. In that case the 4-bit alpha of code 7 is scaled the same way after it has been widened.
- R6: Codes 0, 1 and 2 output alpha equal to the range maximum (255 or 128). The 1-bit alpha of code 6 outputs 0 or the range maximum.
- R7: Code 3 and codes 8..31 output zero on all four channels with out_unsup at 1. Supported codes output out_unsup at 0.
- R8: Pixel bits above the layout's byte count have no effect. Neither does the pad byte of code 2, nor any control bit other than bits 4:0, 5, 6 and 23.
- R9: A pixel accepted at a clock edge (in_valid and in_ready both high) appears on the outputs with out_valid high right after that edge.
- R10: While out_valid is 1 and out_ready is 0, in_ready is 0 and all outputs hold. No accepted pixel is lost or duplicated. When out_valid is 0 or out_ready is 1, in_ready is 1.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source pixel present |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_pixel | input | 32 | Right-aligned packed pixel |
| in_ctl | input | 32 | Plane control word |
| out_valid | output | 1 | Converted pixel present |
| out_ready | input | 1 | Consumer takes the pixel this cycle |
| out_a | output | 8 | Alpha |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |
| out_unsup | output | 1 | Layout code was not recognised |

## Verification
Every result is due exactly one clock edge after the pixel is accepted. The bench therefore drives a pixel at a falling edge and compares all channels and the unsupported flag at the next falling edge, half a period after the registering edge. The stall sequence checks the held pixel at each falling edge while out_ready is low. It then checks that the queued second pixel appears one edge after ready returns, and that out_valid drops one edge after the consumer takes the last pixel.

// File: rtl/pix_expand.sv
module pix_expand #(
  parameter int unsigned PIX_W     = 32,
  parameter int unsigned CTL_W     = 32,
  parameter int unsigned CH_W      = 8,
  parameter int unsigned BE_BIT    = 23,
  parameter int unsigned ASW_BIT   = 6,
  parameter int unsigned AFULL_BIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pixel,
  input  logic [CTL_W-1:0] in_ctl,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CH_W-1:0]  out_a,
  output logic [CH_W-1:0]  out_r,
  output logic [CH_W-1:0]  out_g,
  output logic [CH_W-1:0]  out_b,
  output logic             out_unsup
);
  localparam int unsigned CODE_W = 5;

  function automatic logic [7:0] w5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction
  function automatic logic [7:0] w6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction
  function automatic logic [7:0] w4(input logic [3:0] v);
    return {v, v};
  endfunction

  logic [CODE_W-1:0] code;
  logic              full;
  logic [7:0]        amax;
  logic [2:0]        nbytes;
  logic              known;
  logic [31:0]       pm, pb, q;
  logic [7:0]        a_raw, a_n, r_n, g_n, b_n;
  logic              a_scl;

  assign code = in_ctl[CODE_W-1:0];
  assign full = in_ctl[AFULL_BIT];
  assign amax = full ? 8'hFF : 8'h80;
  assign in_ready = !out_valid || out_ready;

  always_comb begin
    known = 1'b1;
    case (code)
      5'd0, 5'd6, 5'd7: nbytes = 3'd2;
      5'd1, 5'd4:       nbytes = 3'd3;
      5'd2, 5'd5:       nbytes = 3'd4;
      default: begin nbytes = 3'd4; known = 1'b0; end
    endcase
  end

  always_comb begin
    case (nbytes)
      3'd2:    pm = {16'b0, in_pixel[15:0]};
      3'd3:    pm = {8'b0, in_pixel[23:0]};
      default: pm = in_pixel[31:0];
    endcase
    if (!in_ctl[BE_BIT])  pb = pm;
    else if (nbytes == 3'd2) pb = {16'b0, pm[7:0], pm[15:8]};
    else if (nbytes == 3'd3) pb = {8'b0, pm[7:0], pm[15:8], pm[23:16]};
    else                     pb = {pm[7:0], pm[15:8], pm[23:16], pm[31:24]};
    q = pb;
    if (in_ctl[ASW_BIT]) begin
      case (code)
        5'd2, 5'd5: q = {pb[7:0], pb[31:8]};
        5'd4:       q = {8'b0, pb[7:0], pb[23:8]};
        5'd6:       q = {16'b0, pb[0], pb[15:1]};
        5'd7:       q = {16'b0, pb[3:0], pb[15:4]};
        default:    q = pb;
      endcase
    end
  end

  always_comb begin
    a_raw = amax;
    a_scl = 1'b0;
    r_n = '0; g_n = '0; b_n = '0;
    case (code)
      5'd0: begin
        r_n = w5(q[15:11]); g_n = w6(q[10:5]); b_n = w5(q[4:0]);
      end
      5'd1, 5'd2: begin
        r_n = q[23:16]; g_n = q[15:8]; b_n = q[7:0];
      end
      5'd4: begin
        a_raw = q[23:16]; a_scl = 1'b1;
        r_n = w5(q[15:11]); g_n = w6(q[10:5]); b_n = w5(q[4:0]);
      end
      5'd5: begin
        a_raw = q[31:24]; a_scl = 1'b1;
        r_n = q[23:16]; g_n = q[15:8]; b_n = q[7:0];
      end
      5'd6: begin
        a_raw = q[15] ? amax : 8'h00;
        r_n = w5(q[14:10]); g_n = w5(q[9:5]); b_n = w5(q[4:0]);
      end
      5'd7: begin
        a_raw = w4(q[15:12]); a_scl = 1'b1;
        r_n = w4(q[11:8]); g_n = w4(q[7:4]); b_n = w4(q[3:0]);
      end
      default: a_raw = 8'h00;
    endcase
    if (a_scl && !full) a_n = 8'((9'(a_raw) + 9'd1) >> 1);
    else                a_n = a_raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_a <= '0; out_r <= '0; out_g <= '0; out_b <= '0;
      out_unsup <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_a <= a_n; out_r <= r_n; out_g <= g_n; out_b <= b_n;
        out_unsup <= !known;
      end
    end
  end

  // R9
  accept_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_a) && $stable(out_r)
      && $stable(out_g) && $stable(out_b) && $stable(out_unsup)));

  // R6
  opaque_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_ctl[4:0] <= 5'd2) |=>
      (out_a == (in_ctl[AFULL_BIT] ? 8'hFF : 8'h80) || $past(!in_ctl[AFULL_BIT]) && out_a == 8'h80));

  // R7
  unsup_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_ctl[4:0] == 5'd3 || in_ctl[4:3] != 2'b00)) |=>
      (out_unsup && out_a == 8'h00 && out_r == 8'h00 && out_g == 8'h00 && out_b == 8'h00));
endmodule

// File: tb/tb_pix_expand.sv
`timescale 1ns/1ps
module tb_pix_expand;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pixel = '0;
  logic [31:0] in_ctl = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_a, out_r, out_g, out_b;
  logic        out_unsup;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pix_expand dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .in_ctl(in_ctl), .out_valid(out_valid),
    .out_ready(out_ready), .out_a(out_a), .out_r(out_r), .out_g(out_g),
    .out_b(out_b), .out_unsup(out_unsup)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] widen(input int unsigned v, input int w);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[w - 1 - ((7 - i) % w)];
    return r;
  endfunction

  // returns {unsup, a, r, g, b}
  function automatic logic [32:0] model(input logic [31:0] pix, input logic [31:0] ctl);
    int code, nb, aw, wbits;
    int unsigned a, r, g, b, mx;
    logic [31:0] p, s;
    bit full;
    code = int'(ctl[4:0]);
    full = ctl[5];
    mx = full ? 255 : 128;
    case (code)
      0: begin nb = 2; aw = 0; end
      1: begin nb = 3; aw = 0; end
      2: begin nb = 4; aw = 8; end
      4: begin nb = 3; aw = 8; end
      5: begin nb = 4; aw = 8; end
      6: begin nb = 2; aw = 1; end
      7: begin nb = 2; aw = 4; end
      default: return {1'b1, 32'h0};
    endcase
    wbits = nb * 8;
    p = '0;
    for (int i = 0; i < wbits; i++) p[i] = pix[i];
    if (ctl[23]) begin
      s = '0;
      for (int i = 0; i < nb; i++) s[8*i +: 8] = p[8*(nb-1-i) +: 8];
      p = s;
    end
    if (ctl[6] && aw > 0) begin
      s = '0;
      for (int i = 0; i < wbits; i++) s[(i + wbits - aw) % wbits] = p[i];
      p = s;
    end
    a = mx;
    case (code)
      0: begin r = widen(p >> 11, 5); g = widen(p >> 5, 6); b = widen(p, 5); end
      1, 2: begin r = (p >> 16) & 255; g = (p >> 8) & 255; b = p & 255; end
      4: begin a = (p >> 16) & 255; r = widen(p >> 11, 5); g = widen(p >> 5, 6); b = widen(p, 5); end
      5: begin a = p >> 24; r = (p >> 16) & 255; g = (p >> 8) & 255; b = p & 255; end
      6: begin a = p[15] ? mx : 0; r = widen(p >> 10, 5); g = widen(p >> 5, 5); b = widen(p, 5); end
      default: begin a = widen(p >> 12, 4); r = widen(p >> 8, 4); g = widen(p >> 4, 4); b = widen(p, 4); end
    endcase
    if (!full && (code == 4 || code == 5 || code == 7)) a = (a + 1) / 2;
    return {1'b0, a[7:0], r[7:0], g[7:0], b[7:0]};
  endfunction

  function automatic string tag_of(input logic [31:0] ctl);
    int c = int'(ctl[4:0]);
    if (c == 3 || c > 7) return "R7";
    if (ctl[23]) return "R3";
    if (ctl[6]) return "R4";
    if (c <= 2) return "R6";
    if (!ctl[5]) return "R5";
    if (c == 0 || c >= 6) return "R2";
    return "R1";
  endfunction

  task automatic one(input logic [31:0] pix, input logic [31:0] ctl, input string req);
    logic [32:0] e;
    logic [32:0] got;
    e = model(pix, ctl);
    @(negedge clk);
    in_pixel = pix; in_ctl = ctl; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got = {out_unsup, out_a, out_r, out_g, out_b};
    chk(out_valid === 1'b1, "R9", 64'(out_valid), 64'd1);
    chk(got === e, req, 64'(got), 64'(e));
  endtask

  initial begin
    logic [31:0] pats [8];
    logic [32:0] ea, eb, held;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h1234_5678;
    pats[3] = 32'h89AB_CDEF; pats[4] = 32'h5A5A_A5A5; pats[5] = 32'h0F1E_2D3C;
    pats[6] = 32'h8000_0001; pats[7] = 32'h7FFF_8000;

    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R11", 64'(out_valid), 64'd0);
    chk(in_ready === 1'b1, "R11", 64'(in_ready), 64'd1);

    for (int c = 0; c < 32; c++)
      for (int f = 0; f < 8; f++)
        for (int k = 0; k < 8; k++) begin
          logic [31:0] ctl;
          ctl = 32'(c);
          ctl[23] = f[2]; ctl[6] = f[1]; ctl[5] = f[0];
          one(pats[k], ctl, tag_of(ctl));
        end

    for (int av = 0; av < 256; av++) begin
      one({av[7:0], 24'h336699}, 32'h0000_0005, "R5");
      one({av[7:0], 24'h336699}, 32'h0000_0025, "R5");
    end

    // R8: noise above the pixel size, on the pad byte and on unused control bits
    one(32'hDEAD_F81F, 32'h5A00_0000 | 32'h0000_0000, "R8");
    one(32'hAB00_1234, 32'h0000_0001 | 32'h0010_0080, "R8");
    one(32'h7700_1234, 32'h0000_0002, "R8");
    one(32'hCAFE_8421, 32'h0300_0406, "R8");

    // R4 no effect on code 0 and 1
    one(32'h0000_F81F, 32'h0000_0040, "R4");
    one(32'h0012_3456, 32'h0000_0041, "R4");

    // R10 stall
    ea = model(32'h8000_7C00, 32'h0000_0026);
    eb = model(32'h0000_07E0, 32'h0000_0000);
    @(negedge clk);
    out_ready = 1'b0;
    in_pixel = 32'h8000_7C00; in_ctl = 32'h0000_0026; in_valid = 1'b1;
    @(negedge clk);
    held = {out_unsup, out_a, out_r, out_g, out_b};
    chk(out_valid === 1'b1 && held === ea, "R10", 64'(held), 64'(ea));
    chk(in_ready === 1'b0, "R10", 64'(in_ready), 64'd0);
    in_pixel = 32'h0000_07E0; in_ctl = 32'h0000_0000;
    repeat (2) begin
      @(negedge clk);
      held = {out_unsup, out_a, out_r, out_g, out_b};
      chk(out_valid === 1'b1 && held === ea, "R10", 64'(held), 64'(ea));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    held = {out_unsup, out_a, out_r, out_g, out_b};
    chk(out_valid === 1'b1 && held === eb, "R10", 64'(held), 64'(eb));
    @(negedge clk);
    chk(out_valid === 1'b0, "R10", 64'(out_valid), 64'd0);
    chk(in_ready === 1'b1, "R10", 64'(in_ready), 64'd1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule